// File: doc/BRIEF.md
# Irregular Mesh Route Computation Unit

This block is the route computation stage of a router in a two-dimensional mesh where some grid cells are taken up by large rectangular IP blocks, leaving holes in the mesh. For each head flit it receives the current node coordinate, the destination coordinate and a detour-active bit carried in the flit. A node that borders a large block also presents a descriptor of that block: its lower-left corner, its width along x (dimension 0), its height along y (dimension 1), and an edge tag saying whether the block touches a mesh boundary. One clock later the unit returns the output port, the y virtual channel index and the updated detour-active bit.

When nothing is in the way the packet follows x-then-y dimension order. When the dimension-order hop would land inside the described block, the unit instead takes a sidestep at right angles to the direction of travel. The edge tag decides whether only one side is possible. If both sides are possible, the unit estimates the hop count around each side and takes the shorter, with ties going to the positive side. Y hops made while a detour is in progress use virtual channel 1, and all other y hops use channel 0.

The stage is a small state machine. Its state register records the class of the last decision. The states are `ST_IDLE` (no result), `ST_EJECT` (delivered locally), `ST_DOR` (dimension-order hop) and `ST_SIDESTEP` (detour hop). From any state, a cycle with `req_valid` high moves to `ST_EJECT`, `ST_SIDESTEP` or `ST_DOR`, checked in that priority order. A cycle with `req_valid` low moves to `ST_IDLE`.

Top module: `mesh_route_unit`

## Requirements
- R1: After reset, and before any request, `rsp_valid` is 0, `out_port` is the local code 0, and both `out_vc` and `detour_out` are 0.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 after a cycle with `req_valid` low.
- R3: When the current node equals the destination, the result is the local port (code 0), with `out_vc` 0 and `detour_out` 0.
- R4: The port codes are 0 local, 1 x+, 2 x-, 3 y+ and 4 y-. The dimension-order hop moves x toward the destination first, and moves y only when x already matches. This hop is used whenever `obs_valid` is 0, or when the hop's target cell lies outside the block.
- R5: The block covers x from `obs_x` to `obs_x+obs_w-1` and y from `obs_y` to `obs_y+obs_h-1`. If the dimension-order target lies in that rectangle, the unit takes a sidestep on the other axis: y when x was being travelled, x when y was being travelled. It never returns a hop whose target lies inside the block.
- R6: The tag codes are 0 (free on all sides), 1 (touches low y edge), 2 (touches high y edge), 3 (touches low x edge) and 4 (touches high x edge). During x travel, tag 1 forces y+ and tag 2 forces y-. During y travel, tag 3 forces x+ and tag 4 forces x-. In these cases no length comparison is made. Every other combination, including codes 5 to 7, uses the length comparison.
- R7: In the length comparison during x travel, the upper length is (obs_y+obs_h-cur_y) plus the distance from dst_y to obs_y+obs_h. The lower length is (cur_y-obs_y+1) plus the distance from dst_y to obs_y-1. The shorter side wins.
- R8: In the length comparison during y travel, the right length is (obs_x+obs_w-cur_x) plus the distance from dst_x to obs_x+obs_w. The left length is (cur_x-obs_x+1) plus the distance from dst_x to obs_x-1. The shorter side wins.
- R9: When the two lengths are equal, the positive side (y+ or x+) is taken.
- R10: `detour_out` is 1 on every sidestep. On a dimension-order hop it equals `detour_in` AND `obs_valid`, so it clears at the first node that holds no descriptor. It is 0 on a local result.
- R11: `out_vc` is 1 exactly when the chosen port is y+ or y- and `detour_out` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A head flit is presented for routing |
| cur_x | input | COORD_W | Current node x |
| cur_y | input | COORD_W | Current node y |
| dst_x | input | COORD_W | Destination x from the head flit |
| dst_y | input | COORD_W | Destination y from the head flit |
| detour_in | input | 1 | Detour-active bit from the head flit |
| obs_valid | input | 1 | This node holds a block descriptor |
| obs_x | input | COORD_W | Block lower-left x |
| obs_y | input | COORD_W | Block lower-left y |
| obs_w | input | COORD_W | Block width along x |
| obs_h | input | COORD_W | Block height along y |
| obs_tag | input | 3 | Block edge tag |
| rsp_valid | output | 1 | Result valid |
| out_port | output | 3 | Chosen output port code |
| out_vc | output | 1 | Y virtual channel index |
| detour_out | output | 1 | Updated detour-active bit for the flit |

## Verification
The bench builds the unit with COORD_W = 3, which gives an 8 by 8 mesh. It places five blocks in turn: one free block in the interior and one block touching each of the four mesh edges. For every block it sweeps every pair of current and destination nodes outside the block. The descriptor is presented only on the one-cell ring around the block, and the detour-in bit varies between requests. This sweep reaches every sidestep direction, every forced side, equal-length ties and the clearing of the detour bit. For each hop the bench also checks that the target cell stays inside the mesh and outside the block.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_XPOS  = 3'd1,
        P_XNEG  = 3'd2,
        P_YPOS  = 3'd3,
        P_YNEG  = 3'd4
    } port_e;

    typedef enum logic [2:0] {
        TAG_FREE = 3'd0,
        TAG_YLO  = 3'd1,
        TAG_YHI  = 3'd2,
        TAG_XLO  = 3'd3,
        TAG_XHI  = 3'd4
    } tag_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EJECT,
        ST_DOR,
        ST_SIDESTEP
    } state_e;

endpackage

// File: rtl/mrc_dor_dir.sv
module mrc_dor_dir #(
    parameter int DW = 6
) (
    input  logic signed [DW-1:0] cx,
    input  logic signed [DW-1:0] cy,
    input  logic signed [DW-1:0] tx,
    input  logic signed [DW-1:0] ty,
    output mrc_pkg::port_e       dir,
    output logic signed [DW-1:0] nx,
    output logic signed [DW-1:0] ny,
    output logic                 at_dst,
    output logic                 x_travel
);
    import mrc_pkg::*;

    always_comb begin
        at_dst   = (cx == tx) && (cy == ty);
        x_travel = (cx != tx);
        nx       = cx;
        ny       = cy;
        dir      = P_LOCAL;
        if (tx > cx) begin
            dir = P_XPOS;
            nx  = cx + DW'(1);
        end else if (tx < cx) begin
            dir = P_XNEG;
            nx  = cx - DW'(1);
        end else if (ty > cy) begin
            dir = P_YPOS;
            ny  = cy + DW'(1);
        end else if (ty < cy) begin
            dir = P_YNEG;
            ny  = cy - DW'(1);
        end
    end

endmodule

// File: rtl/mrc_block_hit.sv
module mrc_block_hit #(
    parameter int DW = 6
) (
    input  logic                 en,
    input  logic signed [DW-1:0] px,
    input  logic signed [DW-1:0] py,
    input  logic signed [DW-1:0] bx,
    input  logic signed [DW-1:0] by,
    input  logic signed [DW-1:0] bw,
    input  logic signed [DW-1:0] bh,
    output logic                 hit
);
    logic in_x;
    logic in_y;

    always_comb begin
        in_x = (px >= bx) && (px < bx + bw);
        in_y = (py >= by) && (py < by + bh);
        hit  = en && in_x && in_y;
    end

endmodule

// File: rtl/mrc_side_pick.sv
module mrc_side_pick #(
    parameter int DW = 6
) (
    input  logic signed [DW-1:0] cx,
    input  logic signed [DW-1:0] cy,
    input  logic signed [DW-1:0] tx,
    input  logic signed [DW-1:0] ty,
    input  logic signed [DW-1:0] bx,
    input  logic signed [DW-1:0] by,
    input  logic signed [DW-1:0] bw,
    input  logic signed [DW-1:0] bh,
    input  mrc_pkg::tag_e        tag,
    input  logic                 x_travel,
    output mrc_pkg::port_e       side
);
    import mrc_pkg::*;

    logic signed [DW-1:0] pos_edge;
    logic signed [DW-1:0] neg_edge;
    logic signed [DW-1:0] here;
    logic signed [DW-1:0] goal;
    logic signed [DW-1:0] pos_len;
    logic signed [DW-1:0] neg_len;
    logic                 pos_wins;

    // Lengths of the two candidate paths around the block
    always_comb begin
        if (x_travel) begin
            pos_edge = by + bh;
            neg_edge = by - DW'(1);
            here     = cy;
            goal     = ty;
        end else begin
            pos_edge = bx + bw;
            neg_edge = bx - DW'(1);
            here     = cx;
            goal     = tx;
        end
        pos_len = (pos_edge - here)
                + ((goal >= pos_edge) ? (goal - pos_edge) : (pos_edge - goal));
        neg_len = (here - neg_edge)
                + ((goal >= neg_edge) ? (goal - neg_edge) : (neg_edge - goal));
        pos_wins = (pos_len <= neg_len);
    end

    // Edge tag overrides the comparison when only one side exists
    always_comb begin
        if (x_travel) begin
            case (tag)
                TAG_YLO: side = P_YPOS;
                TAG_YHI: side = P_YNEG;
                default: side = pos_wins ? P_YPOS : P_YNEG;
            endcase
        end else begin
            case (tag)
                TAG_XLO: side = P_XPOS;
                TAG_XHI: side = P_XNEG;
                default: side = pos_wins ? P_XPOS : P_XNEG;
            endcase
        end
    end

endmodule

// File: rtl/mesh_route_unit.sv
module mesh_route_unit #(
    parameter int COORD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic               detour_in,
    input  logic               obs_valid,
    input  logic [COORD_W-1:0] obs_x,
    input  logic [COORD_W-1:0] obs_y,
    input  logic [COORD_W-1:0] obs_w,
    input  logic [COORD_W-1:0] obs_h,
    input  logic [2:0]         obs_tag,
    output logic               rsp_valid,
    output logic [2:0]         out_port,
    output logic               out_vc,
    output logic               detour_out
);
    import mrc_pkg::*;

    localparam int DW  = COORD_W + 3;
    localparam int PAD = DW - COORD_W;

    logic signed [DW-1:0] cx, cy, tx, ty, bx, by, bw, bh;
    logic signed [DW-1:0] nx, ny;
    port_e                dor_dir;
    port_e                side_dir;
    port_e                port_d;
    port_e                port_q;
    logic                 at_dst;
    logic                 x_travel;
    logic                 blocked;
    logic                 det_d;
    logic                 det_q;
    state_e               st_d;
    state_e               st_q;
    tag_e                 tag;

    always_comb begin
        cx  = $signed({{PAD{1'b0}}, cur_x});
        cy  = $signed({{PAD{1'b0}}, cur_y});
        tx  = $signed({{PAD{1'b0}}, dst_x});
        ty  = $signed({{PAD{1'b0}}, dst_y});
        bx  = $signed({{PAD{1'b0}}, obs_x});
        by  = $signed({{PAD{1'b0}}, obs_y});
        bw  = $signed({{PAD{1'b0}}, obs_w});
        bh  = $signed({{PAD{1'b0}}, obs_h});
        tag = tag_e'(obs_tag);
    end

    mrc_dor_dir #(.DW(DW)) u_dor (
        .cx(cx), .cy(cy), .tx(tx), .ty(ty),
        .dir(dor_dir), .nx(nx), .ny(ny),
        .at_dst(at_dst), .x_travel(x_travel)
    );

    mrc_block_hit #(.DW(DW)) u_hit (
        .en(obs_valid), .px(nx), .py(ny),
        .bx(bx), .by(by), .bw(bw), .bh(bh),
        .hit(blocked)
    );

    mrc_side_pick #(.DW(DW)) u_side (
        .cx(cx), .cy(cy), .tx(tx), .ty(ty),
        .bx(bx), .by(by), .bw(bw), .bh(bh),
        .tag(tag), .x_travel(x_travel),
        .side(side_dir)
    );

    // Next decision class and the data it carries
    always_comb begin
        if (at_dst) begin
            st_d   = ST_EJECT;
            port_d = P_LOCAL;
            det_d  = 1'b0;
        end else if (blocked) begin
            st_d   = ST_SIDESTEP;
            port_d = side_dir;
            det_d  = 1'b1;
        end else begin
            st_d   = ST_DOR;
            port_d = dor_dir;
            det_d  = detour_in & obs_valid;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= req_valid ? st_d : ST_IDLE;
        end
    end

    // Result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= P_LOCAL;
            det_q  <= 1'b0;
        end else if (req_valid) begin
            port_q <= port_d;
            det_q  <= det_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            ST_IDLE: begin
                rsp_valid  = 1'b0;
                out_port   = port_q;
                out_vc     = 1'b0;
                detour_out = det_q;
            end
            ST_EJECT: begin
                rsp_valid  = 1'b1;
                out_port   = P_LOCAL;
                out_vc     = 1'b0;
                detour_out = 1'b0;
            end
            ST_DOR, ST_SIDESTEP: begin
                rsp_valid  = 1'b1;
                out_port   = port_q;
                out_vc     = det_q && ((port_q == P_YPOS) || (port_q == P_YNEG));
                detour_out = det_q;
            end
        endcase
    end

endmodule

// File: rtl/mesh_route_unit_chk.sv
module mesh_route_unit_chk #(
    parameter int COORD_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [COORD_W-1:0] cur_x,
    input logic [COORD_W-1:0] cur_y,
    input logic [COORD_W-1:0] dst_x,
    input logic [COORD_W-1:0] dst_y,
    input logic               obs_valid,
    input logic               rsp_valid,
    input logic [2:0]         out_port,
    input logic               out_vc,
    input logic               detour_out
);

    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r3_eject_local: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_x == dst_x && cur_y == dst_y)
        |=> (out_port == 3'd0 && !out_vc && !detour_out));

    a_r4_no_local_en_route: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (cur_x != dst_x || cur_y != dst_y)) |=> (out_port != 3'd0));

    a_r4_clear_path_xpos: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !obs_valid && dst_x > cur_x) |=> (out_port == 3'd1));

    a_r10_no_descriptor_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !obs_valid) |=> !detour_out);

    a_r11_vc_only_on_y_detour: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && out_vc) |-> ((out_port == 3'd3 || out_port == 3'd4) && detour_out));

endmodule

bind mesh_route_unit mesh_route_unit_chk #(.COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .obs_valid(obs_valid), .rsp_valid(rsp_valid), .out_port(out_port),
    .out_vc(out_vc), .detour_out(detour_out)
);

// File: tb/tb_mesh_route_unit.sv
module tb_mesh_route_unit;

    localparam int CW = 3;
    localparam int SZ = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [CW-1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
    logic          detour_in = 1'b0;
    logic          obs_valid = 1'b0;
    logic [CW-1:0] obs_x = '0, obs_y = '0, obs_w = '0, obs_h = '0;
    logic [2:0]    obs_tag = '0;
    logic          rsp_valid;
    logic [2:0]    out_port;
    logic          out_vc;
    logic          detour_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mesh_route_unit #(.COORD_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
        .detour_in(detour_in), .obs_valid(obs_valid),
        .obs_x(obs_x), .obs_y(obs_y), .obs_w(obs_w), .obs_h(obs_h),
        .obs_tag(obs_tag), .rsp_valid(rsp_valid), .out_port(out_port),
        .out_vc(out_vc), .detour_out(detour_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic bit inside_blk(input int x, input int y, input int bx,
                                      input int by, input int bw, input int bh);
        return (x >= bx) && (x < bx + bw) && (y >= by) && (y < by + bh);
    endfunction

    // Reference decision from the requirements
    task automatic model(input int cx, input int cy, input int tx, input int ty,
                         input int di, input int ov, input int bx, input int by,
                         input int bw, input int bh, input int tg,
                         output int port, output int vc, output int det);
        int nx, ny, dp, pl, nl;
        if (cx == tx && cy == ty) begin
            port = 0; vc = 0; det = 0;
            return;
        end
        nx = cx; ny = cy;
        if (tx > cx)      begin dp = 1; nx = cx + 1; end
        else if (tx < cx) begin dp = 2; nx = cx - 1; end
        else if (ty > cy) begin dp = 3; ny = cy + 1; end
        else              begin dp = 4; ny = cy - 1; end
        if (ov != 0 && inside_blk(nx, ny, bx, by, bw, bh)) begin
            det = 1;
            if (cx != tx) begin
                pl = (by + bh - cy) + iabs(ty - (by + bh));
                nl = (cy - by + 1) + iabs(ty - (by - 1));
                if (tg == 1)      port = 3;
                else if (tg == 2) port = 4;
                else              port = (pl <= nl) ? 3 : 4;
            end else begin
                pl = (bx + bw - cx) + iabs(tx - (bx + bw));
                nl = (cx - bx + 1) + iabs(tx - (bx - 1));
                if (tg == 3)      port = 1;
                else if (tg == 4) port = 2;
                else              port = (pl <= nl) ? 1 : 2;
            end
        end else begin
            port = dp;
            det  = (di != 0 && ov != 0) ? 1 : 0;
        end
        vc = (det == 1 && (port == 3 || port == 4)) ? 1 : 0;
    endtask

    task automatic sweep_block(input int bx, input int by, input int bw,
                               input int bh, input int tg);
        int ep, ev, ed, hx, hy, ov, di;
        obs_x = CW'(bx); obs_y = CW'(by); obs_w = CW'(bw); obs_h = CW'(bh);
        obs_tag = 3'(tg);
        for (int cx = 0; cx < SZ; cx++) begin
            for (int cy = 0; cy < SZ; cy++) begin
                if (inside_blk(cx, cy, bx, by, bw, bh)) continue;
                ov = (cx >= bx - 1 && cx <= bx + bw && cy >= by - 1 && cy <= by + bh) ? 1 : 0;
                for (int tx = 0; tx < SZ; tx++) begin
                    for (int ty = 0; ty < SZ; ty++) begin
                        if (inside_blk(tx, ty, bx, by, bw, bh)) continue;
                        di = (cx + ty + tx) & 1;
                        req_valid = 1'b1;
                        cur_x = CW'(cx); cur_y = CW'(cy);
                        dst_x = CW'(tx); dst_y = CW'(ty);
                        detour_in = di[0];
                        obs_valid = ov[0];
                        model(cx, cy, tx, ty, di, ov, bx, by, bw, bh, tg, ep, ev, ed);
                        @(negedge clk);
                        check("R2 rsp_valid", int'(rsp_valid), 1);
                        if (ep == 0) check("R3 local port", int'(out_port), ep);
                        else if (ov == 0) check("R4 clear-path port", int'(out_port), ep);
                        else if (tg == 0) check("R7 R8 R9 side choice", int'(out_port), ep);
                        else check("R5 R6 hop with tagged block", int'(out_port), ep);
                        check("R10 detour bit", int'(detour_out), ed);
                        check("R11 vc", int'(out_vc), ev);
                        hx = cx; hy = cy;
                        case (out_port)
                            3'd1: hx = cx + 1;
                            3'd2: hx = cx - 1;
                            3'd3: hy = cy + 1;
                            3'd4: hy = cy - 1;
                            default: ;
                        endcase
                        check("R5 hop stays in mesh and off block",
                              int'(hx >= 0 && hx < SZ && hy >= 0 && hy < SZ &&
                                   !inside_blk(hx, hy, bx, by, bw, bh)), 1);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rsp_valid", int'(rsp_valid), 0);
        check("R1 reset port", int'(out_port), 0);
        check("R1 reset vc", int'(out_vc), 0);
        check("R1 reset detour", int'(detour_out), 0);

        sweep_block(2, 2, 3, 2, 0);   // interior, two-sided
        sweep_block(3, 0, 2, 3, 1);   // touches low y edge
        sweep_block(1, 5, 3, 3, 2);   // touches high y edge
        sweep_block(0, 3, 2, 2, 3);   // touches low x edge
        sweep_block(5, 3, 3, 2, 4);   // touches high x edge

        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle after request", int'(rsp_valid), 0);
        @(negedge clk);
        check("R2 stays idle", int'(rsp_valid), 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule